// File: doc/BRIEF.md
# Dual-Channel DAC Host Port

This block is the digital front end of a two-channel, 12-bit, current-output converter that a host drives over a parallel bus. It samples the host's strobe and control pins in the system clock domain. For each channel it keeps two registers: a staging latch and a DAC register. The two DAC registers drive the codes that would feed the converter ladders. The bidirectional data bus is split into an input word, an output word and an output enable that a pad ring would combine.

The host writes by pulling the select strobe low with the direction pin low. The word is taken in when the strobe returns high. A load pin chooses how the DAC register follows the staging latch:

- **Load pin held low:** the DAC register updates together with the latch, on the strobe's rising edge.
- **Load pin held high:** writes stop at the latch. A later falling edge on the load pin moves both latches into both DAC registers at once.

With the direction pin high, a strobe cycle reads the addressed DAC register back onto the bus. The same read copies that value into the channel's latch. A clear pin zeroes everything, and so does reset.

Top module: `pdac_host_port`

## Requirements
- R1: After reset, code_a, code_b and data_out are 0 and data_oe is 0.
- R2: With ldac_n low, a write (cs_n low, then high, with rw low) loads data_in into the addressed channel's DAC register. ab_sel=0 addresses channel A and ab_sel=1 addresses channel B. The other channel's code does not change.
- R3: While cs_n stays low, neither the codes nor the staging latches take the bus word. The word captured is the one present during the last sampled low cycle of cs_n.
- R4: With ldac_n high, a write changes only the staging latch, so both codes stay unchanged. A falling edge of ldac_n copies each channel's latch into its DAC register.
- R5: While cs_n is low and rw is high, data_oe is 1 and data_out equals the addressed channel's DAC register. That value is also written into the channel's staging latch.
- R6: data_oe is 0 whenever cs_n has been sampled high. It falls on the third clock edge after cs_n rises.
- R7: While clr_n is low, both codes read 0 and both staging latches are zeroed. A later ldac_n falling edge therefore still gives 0.
- R8: A clear and a write that land in the same cycle leave the codes at 0.
- R9: In the write-through mode, a code changes on the third rising clock edge after cs_n rises. It still holds the old value after the second edge.
- R10: A read cycle leaves both codes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Bus strobe, active low, asynchronous |
| rw | input | 1 | Direction: 0 write, 1 read |
| ab_sel | input | 1 | Channel address: 0 A, 1 B |
| ldac_n | input | 1 | Load control: held low for write-through; a falling edge loads both channels |
| clr_n | input | 1 | Clear, active low |
| data_in | input | 12 | Bus word from host |
| data_out | output | 12 | Readback word, 0 when not reading |
| data_oe | output | 1 | Bus drive enable for readback |
| code_a | output | 12 | Channel A DAC register |
| code_b | output | 12 | Channel B DAC register |

## Verification
The latch of a channel has no port of its own. A corrupt latch therefore shows up only when an ldac_n falling edge exposes it on a code output, three clock edges after that edge. The bench forces that exposure after a held strobe, after a readback and after a clear. A wrong DAC register shows up on code_a or code_b at once, and on data_out during the next read. Timing faults in the edge detection show up as a code or data_oe that moves one edge early or late around a cs_n rise.

// File: rtl/pdac_pkg.sv
package pdac_pkg;
  localparam int PDAC_NCH = 2;
  typedef enum logic { CH_A = 1'b0, CH_B = 1'b1 } pdac_ch_e;
endpackage

// File: rtl/pdac_sync.sv
module pdac_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[i] <= INIT;
      else if (i == 0) st[i] <= d;
      else st[i] <= st[(i == 0) ? 0 : i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/pdac_chan.sv
module pdac_chan #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         lat_wr,
  input  logic [W-1:0] lat_d,
  input  logic         wr_through,
  input  logic         bulk_ld,
  input  logic         rd_copy,
  output logic [W-1:0] dac_q
);
  logic [W-1:0] stage_q;

  // staging latch: readback copy and host write never coincide
  always_ff @(posedge clk) begin
    if (rst || clr) stage_q <= '0;
    else if (rd_copy) stage_q <= dac_q;
    else if (lat_wr) stage_q <= lat_d;
  end

  // DAC register: a write-through of the new word beats a bulk load
  always_ff @(posedge clk) begin
    if (rst || clr) dac_q <= '0;
    else if (wr_through) dac_q <= lat_d;
    else if (bulk_ld) dac_q <= stage_q;
  end

  assert property (@(posedge clk) disable iff (rst)
    clr |=> (dac_q == '0))
    else $error("assert_clear_zero_R7");
endmodule

// File: rtl/pdac_host_port.sv
module pdac_host_port #(
  parameter int DW = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          rw,
  input  logic          ab_sel,
  input  logic          ldac_n,
  input  logic          clr_n,
  input  logic [DW-1:0] data_in,
  output logic [DW-1:0] data_out,
  output logic          data_oe,
  output logic [DW-1:0] code_a,
  output logic [DW-1:0] code_b
);
  import pdac_pkg::*;

  localparam int PW = DW + 5;
  localparam logic [PW-1:0] PIN_IDLE = {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, {DW{1'b0}}};

  logic [PW-1:0] pin_raw, pin_s;
  logic          cs_s, rw_s, sel_s, ldac_s, clr_s;
  logic [DW-1:0] din_s;

  assign pin_raw = {cs_n, rw, ab_sel, ldac_n, clr_n, data_in};

  pdac_sync #(.W(PW), .STAGES(SYNC_STAGES), .INIT(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(pin_raw), .q(pin_s)
  );

  assign {cs_s, rw_s, sel_s, ldac_s, clr_s, din_s} = pin_s;

  // edge history and the bus state held from the last low strobe cycle
  logic          cs_d, ldac_d, hold_rw, hold_sel;
  logic [DW-1:0] hold_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d     <= 1'b1;
      ldac_d   <= 1'b1;
      hold_rw  <= 1'b1;
      hold_sel <= CH_A;
      hold_d   <= '0;
    end else begin
      cs_d   <= cs_s;
      ldac_d <= ldac_s;
      if (!cs_s) begin
        hold_rw  <= rw_s;
        hold_sel <= sel_s;
        hold_d   <= din_s;
      end
    end
  end

  logic cs_rise, wr_stb, ldac_fall, rd_now;
  assign cs_rise   = cs_s & ~cs_d;
  assign wr_stb    = cs_rise & ~hold_rw;
  assign ldac_fall = ~ldac_s & ldac_d;
  assign rd_now    = ~cs_s & rw_s;

  logic [DW-1:0] dac_q [PDAC_NCH];

  for (genvar c = 0; c < PDAC_NCH; c++) begin : g_ch
    logic hit_wr;
    assign hit_wr = wr_stb && (hold_sel == 1'(c));
    pdac_chan #(.W(DW)) u_chan (
      .clk(clk),
      .rst(rst),
      .clr(~clr_s),
      .lat_wr(hit_wr),
      .lat_d(hold_d),
      .wr_through(hit_wr && !ldac_s),
      .bulk_ld(ldac_fall),
      .rd_copy(rd_now && (sel_s == 1'(c))),
      .dac_q(dac_q[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_out <= '0;
      data_oe  <= 1'b0;
    end else begin
      data_out <= rd_now ? dac_q[sel_s] : '0;
      data_oe  <= rd_now;
    end
  end

  assign code_a = dac_q[CH_A];
  assign code_b = dac_q[CH_B];

  assert property (@(posedge clk) disable iff (rst)
    (!cs_s && !ldac_fall && clr_s) |=> ($stable(code_a) && $stable(code_b)))
    else $error("assert_cs_low_holds_R3");

  assert property (@(posedge clk) disable iff (rst)
    (wr_stb && ldac_s && !ldac_fall && clr_s) |=> ($stable(code_a) && $stable(code_b)))
    else $error("assert_strobe_mode_hold_R4");

  assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !hold_sel && !ldac_fall && clr_s) |=> $stable(code_b))
    else $error("assert_channel_isolation_R2");

  assert property (@(posedge clk) disable iff (rst)
    (rd_now && clr_s) |=> (data_out == (sel_s ? code_b : code_a)))
    else $error("assert_readback_match_R5");

  assert property (@(posedge clk) disable iff (rst)
    cs_rise |=> !data_oe)
    else $error("assert_oe_release_R6");

  assert property (@(posedge clk) disable iff (rst)
    (!clr_s && cs_rise) |=> (code_a == '0 && code_b == '0))
    else $error("assert_clear_beats_write_R8");
endmodule

// File: tb/tb_pdac_host_port.sv
`timescale 1ns/1ps
module tb_pdac_host_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, rw = 1'b0, ab_sel = 1'b0, ldac_n = 1'b0, clr_n = 1'b1;
  logic [11:0] data_in = '0;
  logic [11:0] data_out, code_a, code_b;
  logic        data_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pdac_host_port dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rw(rw), .ab_sel(ab_sel),
    .ldac_n(ldac_n), .clr_n(clr_n), .data_in(data_in),
    .data_out(data_out), .data_oe(data_oe), .code_a(code_a), .code_b(code_b)
  );

  // op: 0 write, 1 read, 2 ldac pulse | sel | ldac level | data | exp A | exp B | exp read
  localparam logic [51:0] VEC [8] = '{
    {2'd0, 1'b0, 1'b0, 12'h5A3, 12'h5A3, 12'h000, 12'h000},
    {2'd0, 1'b1, 1'b0, 12'hFFF, 12'h5A3, 12'hFFF, 12'h000},
    {2'd0, 1'b0, 1'b0, 12'h000, 12'h000, 12'hFFF, 12'h000},
    {2'd0, 1'b1, 1'b1, 12'h800, 12'h000, 12'hFFF, 12'h000},
    {2'd0, 1'b0, 1'b1, 12'h7FF, 12'h000, 12'hFFF, 12'h000},
    {2'd2, 1'b0, 1'b1, 12'h000, 12'h7FF, 12'h800, 12'h000},
    {2'd0, 1'b0, 1'b0, 12'h001, 12'h001, 12'h800, 12'h000},
    {2'd1, 1'b1, 1'b0, 12'h000, 12'h001, 12'h800, 12'h800}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic sel, input logic [11:0] d, input logic ld);
    ldac_n = ld;
    tick(3);
    rw = 1'b0; ab_sel = sel; data_in = d; cs_n = 1'b0;
    tick(4);
    cs_n = 1'b1;
    tick(5);
  endtask

  task automatic do_read(input logic sel, input logic [11:0] exp);
    rw = 1'b1; ab_sel = sel; cs_n = 1'b0;
    tick(5);
    chk("R5 oe during read", 32'(data_oe), 32'd1);
    chk("R5 readback word", 32'(data_out), 32'(exp));
    cs_n = 1'b1;
    tick(5);
    chk("R6 oe after read", 32'(data_oe), 32'd0);
    rw = 1'b0;
    tick(2);
  endtask

  task automatic pulse_ldac();
    ldac_n = 1'b1; tick(3);
    ldac_n = 1'b0; tick(4);
    ldac_n = 1'b1; tick(4);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(4);
    // R1 reset state
    chk("R1 code_a", 32'(code_a), 32'd0);
    chk("R1 code_b", 32'(code_b), 32'd0);
    chk("R1 data_out", 32'(data_out), 32'd0);
    chk("R1 data_oe", 32'(data_oe), 32'd0);

    for (int i = 0; i < 8; i++) begin
      logic [1:0]  op;
      logic        sel, ld;
      logic [11:0] d, ea, eb, er;
      {op, sel, ld, d, ea, eb, er} = VEC[i];
      case (op)
        2'd0: do_write(sel, d, ld);
        2'd1: do_read(sel, er);
        default: pulse_ldac();
      endcase
      if (op == 2'd0 && !ld) begin
        chk("R2 vector code_a", 32'(code_a), 32'(ea));
        chk("R2 vector code_b", 32'(code_b), 32'(eb));
      end else if (op == 2'd1) begin
        chk("R10 vector code_a", 32'(code_a), 32'(ea));
        chk("R10 vector code_b", 32'(code_b), 32'(eb));
      end else begin
        chk("R4 vector code_a", 32'(code_a), 32'(ea));
        chk("R4 vector code_b", 32'(code_b), 32'(eb));
      end
    end

    // R9 latency of a write-through
    rw = 1'b0; ab_sel = 1'b0; data_in = 12'h3C3; cs_n = 1'b0;
    tick(4);
    cs_n = 1'b1;
    tick(2);
    chk("R9 old code after two edges", 32'(code_a), 32'h001);
    tick(1);
    chk("R9 new code after three edges", 32'(code_a), 32'h3C3);
    tick(3);

    // R3 latch is not transparent while strobe held low
    do_write(1'b0, 12'h111, 1'b1);
    pulse_ldac();
    chk("R4 pulse loads A", 32'(code_a), 32'h111);
    rw = 1'b0; ab_sel = 1'b0; data_in = 12'h222; cs_n = 1'b0;
    tick(5);
    chk("R3 code held while cs low", 32'(code_a), 32'h111);
    pulse_ldac();
    chk("R3 latch untouched while cs low", 32'(code_a), 32'h111);
    cs_n = 1'b1;
    tick(5);
    chk("R4 strobe mode write holds code", 32'(code_a), 32'h111);
    pulse_ldac();
    chk("R3 word taken at cs rise", 32'(code_a), 32'h222);

    // R5 readback overwrites the latch, R10 read leaves codes alone
    do_write(1'b0, 12'h456, 1'b1);
    chk("R4 latch-only write", 32'(code_a), 32'h222);
    do_read(1'b0, 12'h222);
    chk("R10 code after read", 32'(code_a), 32'h222);
    pulse_ldac();
    chk("R5 latch got DAC value", 32'(code_a), 32'h222);

    // R6 output enable release timing
    rw = 1'b1; ab_sel = 1'b1; cs_n = 1'b0;
    tick(5);
    chk("R6 oe asserted", 32'(data_oe), 32'd1);
    cs_n = 1'b1;
    tick(2);
    chk("R6 oe still set after two edges", 32'(data_oe), 32'd1);
    tick(1);
    chk("R6 oe cleared after three edges", 32'(data_oe), 32'd0);
    rw = 1'b0;
    tick(3);

    // R7 clear
    do_write(1'b1, 12'h9AB, 1'b0);
    chk("R2 channel B write", 32'(code_b), 32'h9AB);
    clr_n = 1'b0;
    tick(5);
    chk("R7 clear code_a", 32'(code_a), 32'd0);
    chk("R7 clear code_b", 32'(code_b), 32'd0);
    clr_n = 1'b1;
    tick(3);
    pulse_ldac();
    chk("R7 latch A cleared", 32'(code_a), 32'd0);
    chk("R7 latch B cleared", 32'(code_b), 32'd0);

    // R8 clear against a simultaneous write
    ldac_n = 1'b0;
    tick(3);
    rw = 1'b0; ab_sel = 1'b0; data_in = 12'hABC; cs_n = 1'b0;
    tick(5);
    cs_n = 1'b1; clr_n = 1'b0;
    tick(3);
    chk("R8 clear wins", 32'(code_a), 32'd0);
    clr_n = 1'b1;
    tick(5);
    chk("R8 code stays zero", 32'(code_a), 32'd0);

    summary();
  end
endmodule